// File: doc/BRIEF.md
# Two-digit BCD-to-binary converter

This block turns a packed decimal byte, holding a tens digit in the upper nibble and a units digit in the lower nibble, into a 7-bit unsigned binary number from 0 to 99. The result is the sum of a fixed weight for every set BCD bit. The units bits weigh 1, 2, 4 and 8, and the tens bits weigh 10, 20, 40 and 80. The block forms this sum in two passes through 4-bit adder slices. The first pass adds the shifted units digit to the tens digit. The second pass adds the tens digit moved two columns up, with a carry passed from the lower slice to the upper one. Bit 0 of the result is the units LSB and needs no adder.

A caller presents a byte with a one-cycle valid strobe. On the next clock the result appears at the output together with a valid flag. If either nibble is greater than 9, the error flag rises with that result and the binary output is forced to zero. When no strobe is present, the result register keeps its last value.

Top module: `bcd2bin_conv`

## Requirements
- R1: For every legal input (both nibbles 0 to 9), out_bin equals tens*10 + units, where tens is in_bcd[7:4] and units is in_bcd[3:0].
- R2: An input with exactly one set bit gives that bit's weight. Bits 0 to 3 weigh 1, 2, 4 and 8. Bits 4 to 7 weigh 10, 20, 40 and 80.
- R3: The input 8'h52 (0101 0010) produces out_bin = 7'b0110100 (52).
- R4: out_vld is high in the cycle after a clock edge at which in_vld was high, and low after an edge at which in_vld was low.
- R5: If either nibble is greater than 9, the result of that conversion has out_err = 1 and out_bin = 0. A legal input gives out_err = 0.
- R6: While in_vld is low, out_bin holds its previous value and out_err is low.
- R7: A synchronous active-high rst clears out_bin, out_vld and out_err to 0.
- R8: The largest legal input, 8'h99, gives 99, and 8'h00 gives 0, with out_err = 0 in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_bcd | input | 8 | Packed BCD: tens in [7:4], units in [3:0] |
| in_vld | input | 1 | Input strobe; converts in_bcd at this edge |
| out_bin | output | 7 | Registered binary result |
| out_vld | output | 1 | Result valid, one cycle after the strobe |
| out_err | output | 1 | A nibble of the converted input exceeded 9 |

## Verification
The properties assume that in_bcd is stable at every rising edge where in_vld is high. They also assume that rst is the only thing that starts a clean state, so every check is disabled while rst is high. The stimulus changes in_bcd and in_vld only on falling clock edges, and it raises in_vld for a single cycle per conversion. Idle gaps between strobes exercise the hold and deassertion behaviour. Illegal nibbles are applied deliberately, and all 156 such bytes are covered, so the error properties see every case they cover.

// File: rtl/bcd2bin_conv.sv
module bcd2bin_conv (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_bcd,
  input  logic       in_vld,
  output logic [6:0] out_bin,
  output logic       out_vld,
  output logic       out_err
);

  function automatic logic [4:0] slice4(input logic [3:0] a, input logic [3:0] b, input logic ci);
    return {1'b0, a} + {1'b0, b} + {4'b0000, ci};
  endfunction

  logic [3:0] units, tens;
  logic [4:0] pass1, lo, hi;
  logic [9:0] sum_full;
  logic       bad;

  assign units = in_bcd[3:0];
  assign tens  = in_bcd[7:4];

  // columns b1..b4: units>>1 plus tens (weights 2 and 8 of 10*tens)
  assign pass1 = slice4({1'b0, units[3:1]}, tens, 1'b0);
  // add tens<<2 across columns b1..b8, carry rippling low to high
  assign lo = slice4(pass1[3:0], {tens[1:0], 2'b00}, 1'b0);
  assign hi = slice4({3'b000, pass1[4]}, {2'b00, tens[3:2]}, lo[4]);

  assign sum_full = {hi, lo[3:0], units[0]};
  assign bad = (units > 4'd9) || (tens > 4'd9) || (|sum_full[9:7]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bin <= '0;
      out_vld <= 1'b0;
      out_err <= 1'b0;
    end else begin
      out_vld <= in_vld;
      out_err <= in_vld && bad;
      if (in_vld) out_bin <= bad ? 7'd0 : sum_full[6:0];
    end
  end

endmodule

module bcd2bin_conv_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] in_bcd,
  input logic       in_vld,
  input logic [6:0] out_bin,
  input logic       out_vld,
  input logic       out_err
);

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst) out_err |-> (out_bin == 7'd0)); // R5
  AST_RANGE: assert property (@(posedge clk) disable iff (rst) (out_vld && !out_err) |-> (out_bin <= 7'd99)); // R1
  AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld); // R4
  AST_VLD_FALL: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld); // R4
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (in_bcd[3:0] > 4'd9 || in_bcd[7:4] > 4'd9)) |=> out_err); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !in_vld |=> ($stable(out_bin) && !out_err)); // R6

endmodule

bind bcd2bin_conv bcd2bin_conv_chk u_chk (.*);

// File: tb/tb_bcd2bin_conv.sv
module tb_bcd2bin_conv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_bcd = 8'h00;
  logic       in_vld = 1'b0;
  logic [6:0] out_bin;
  logic       out_vld, out_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bcd2bin_conv dut (.*);

  always #10 clk = ~clk;

  // {bcd, err, bin}
  localparam logic [15:0] VEC [12] = '{
    {8'h52, 1'b0, 7'd52}, {8'h01, 1'b0, 7'd1},  {8'h02, 1'b0, 7'd2},
    {8'h04, 1'b0, 7'd4},  {8'h08, 1'b0, 7'd8},  {8'h10, 1'b0, 7'd10},
    {8'h20, 1'b0, 7'd20}, {8'h40, 1'b0, 7'd40}, {8'h80, 1'b0, 7'd80},
    {8'h99, 1'b0, 7'd99}, {8'h00, 1'b0, 7'd0},  {8'hA0, 1'b1, 7'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input logic [7:0] b);
    @(negedge clk);
    in_bcd = b;
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset bin", out_bin, 0);
    check("R7 reset vld", out_vld, 0);
    check("R7 reset err", out_err, 0);
    rst = 1'b0;

    for (int i = 0; i < 12; i++) begin
      convert(VEC[i][15:8]);
      check(i == 0 ? "R3 example" : (i >= 9 && i <= 10) ? "R8 edge" : (i == 11) ? "R5 err" : "R2 weight",
            out_bin, VEC[i][6:0]);
      check("R5 err flag", out_err, VEC[i][7]);
      check("R4 vld", out_vld, 1);
    end

    for (int t = 0; t < 10; t++)
      for (int u = 0; u < 10; u++) begin
        convert({t[3:0], u[3:0]});
        check("R1 legal", out_bin, t * 10 + u);
        check("R5 legal no err", out_err, 0);
      end

    for (int v = 0; v < 256; v++)
      if (v[3:0] > 9 || v[7:4] > 9) begin
        convert(v[7:0]);
        check("R5 illegal err", out_err, 1);
        check("R5 illegal zero", out_bin, 0);
      end

    convert(8'h37);
    check("R1 before hold", out_bin, 37);
    in_bcd = 8'h64;
    repeat (3) @(negedge clk);
    check("R6 hold bin", out_bin, 37);
    check("R6 hold err", out_err, 0);
    check("R4 vld low", out_vld, 0);

    convert(8'h85);
    check("R1 after idle", out_bin, 85);
    @(negedge clk);
    in_bcd = 8'h42;
    in_vld = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check("R7 sync reset bin", out_bin, 0);
    check("R7 sync reset vld", out_vld, 0);
    check("R7 sync reset err", out_err, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule